// File: doc/BRIEF.md
# Configuration Commit Synchronizer

This block carries control settings from a register-bus clock domain into a separate serial-interface clock domain. Software first writes three staging registers: the operating mode, the serial-clock setting and the instruction-frame setting. These values do not reach the interface side until software writes a commit command. The commit then copies all three into the interface domain together, as a single update.

The same path carries the other control commands: enable, disable, soft reset, start-transfer and end-of-transfer. Each accepted command toggles a request line. The interface domain answers with an acknowledge toggle. Each direction passes through its own flop synchronizer. A busy flag in the status register stays high from the accepted write until the acknowledge is back in the bus domain. Software polls this flag before it issues the next command.

Register map, by word address on the bus port: 0 = command (write only), 1 = mode staging, 2 = serial-clock staging, 3 = frame staging, 4 = status.

Top module: `cdc_cfg_commit`

## Requirements
- R1: After reset the following are all zero: status, staging registers, interface configuration outputs, `if_enabled` and all strobe outputs.
- R2: Writes to addresses 1, 2 and 3 can be read back from the same address. They leave `cfg_mode`, `cfg_sclk` and `cfg_frame` unchanged.
- R3: A write to address 0 with bit 8 set (commit) loads all three staging values onto the interface configuration outputs. Those outputs change only when a command arrives in the interface domain.
- R4: Status bit 0 (busy) is 1 from the cycle after a command is accepted until the acknowledge returns. It is 0 when no transfer is pending.
- R5: Command bit 0 (enable) sets `if_enabled`. Bit 1 (disable) clears it, and disable wins when both bits are set. Status bit 1 reports the enabled state only after the command has crossed, so it reads 0 while busy is still set.
- R6: Command bit 9 produces exactly one interface-clock pulse on `start_pulse`. Command bit 24 produces exactly one pulse on `last_pulse`.
- R7: Any write made while busy is ignored, whether it targets a command or a staging register, and it sets status bit 2 (error). Reading status returns the error bit and then clears it.
- R8: Command bit 7 (soft reset) clears the staging registers at once. In the interface domain it clears the committed configuration and the enabled state, and it pulses `srst_pulse` for one interface clock. It overrides every other command bit written with it.
- R9: A write to address 0 with none of bits 0, 1, 7, 8, 9 or 24 set is not a command and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Register-bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Registered read data, valid one cycle after rd_en |
| iclk | input | 1 | Serial-interface clock |
| irst | input | 1 | Synchronous active-high reset, interface domain |
| cfg_mode | output | MODE_W | Committed mode setting |
| cfg_sclk | output | SCLK_W | Committed serial-clock setting |
| cfg_frame | output | DATA_W | Committed instruction-frame setting |
| if_enabled | output | 1 | Interface-domain enabled state |
| start_pulse | output | 1 | One-cycle start-transfer strobe |
| last_pulse | output | 1 | One-cycle end-of-transfer strobe |
| srst_pulse | output | 1 | One-cycle soft-reset strobe |

## Verification
The bench writes to a staging register while a commit is still in flight. A design that did not hold its staging registers would let the later value leak into the committed configuration.

It also issues a start command while busy. A design that accepted commands during busy would emit a strobe that the pulse scoreboard never expected.

Two further cases target the status bits. The enabled bit is read while busy is still set, which catches a design that reports enable before the command has crossed. The error flag is read twice, which catches an error bit that is not sticky or that is not cleared by a read.

The last case is a soft reset written together with a start. Here a design that gave reset lower priority would emit a start strobe or keep stale configuration.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  // Command bit positions inside a write to the command address.
  localparam int CMD_EN     = 0;
  localparam int CMD_DIS    = 1;
  localparam int CMD_SRST   = 7;
  localparam int CMD_COMMIT = 8;
  localparam int CMD_START  = 9;
  localparam int CMD_LAST   = 24;

  // Word addresses on the register port.
  localparam int ADDR_CMD   = 0;
  localparam int ADDR_MODE  = 1;
  localparam int ADDR_SCLK  = 2;
  localparam int ADDR_FRAME = 3;
  localparam int ADDR_STAT  = 4;

  typedef struct packed {
    logic en;
    logic dis;
    logic srst;
    logic commit;
    logic start;
    logic last;
  } cmd_t;
endpackage

// File: rtl/ccs_sync2.sv
module ccs_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ccs_bus_regs.sv
module ccs_bus_regs
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int MODE_W = 16,
  parameter int SCLK_W = 24
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack_s,
  input  logic              en_s,
  output logic              req_tgl,
  output cmd_t              cmd_q,
  output logic [MODE_W-1:0] mode_sh,
  output logic [SCLK_W-1:0] sclk_sh,
  output logic [DATA_W-1:0] frame_sh,
  output logic              busy,
  output logic              err
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(ADDR_CMD);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADDR_MODE);
  localparam logic [ADDR_W-1:0] A_SCLK  = ADDR_W'(ADDR_SCLK);
  localparam logic [ADDR_W-1:0] A_FRAME = ADDR_W'(ADDR_FRAME);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADDR_STAT);

  cmd_t wcmd;
  assign wcmd.en     = wr_data[CMD_EN];
  assign wcmd.dis    = wr_data[CMD_DIS];
  assign wcmd.srst   = wr_data[CMD_SRST];
  assign wcmd.commit = wr_data[CMD_COMMIT];
  assign wcmd.start  = wr_data[CMD_START];
  assign wcmd.last   = wr_data[CMD_LAST];

  always_ff @(posedge bclk) begin
    if (brst) begin
      req_tgl  <= 1'b0;
      cmd_q    <= '0;
      mode_sh  <= '0;
      sclk_sh  <= '0;
      frame_sh <= '0;
      busy     <= 1'b0;
      err      <= 1'b0;
    end else begin
      // Acknowledge has come back: transfer complete.
      if (busy && (ack_s == req_tgl)) busy <= 1'b0;
      if (rd_en && rd_addr == A_STAT) err <= 1'b0;
      if (wr_en) begin
        if (busy) begin
          err <= 1'b1;
        end else begin
          case (wr_addr)
            A_CMD: begin
              if (|wcmd) begin
                cmd_q   <= wcmd;
                req_tgl <= ~req_tgl;
                busy    <= 1'b1;
                if (wcmd.srst) begin
                  mode_sh  <= '0;
                  sclk_sh  <= '0;
                  frame_sh <= '0;
                end
              end
            end
            A_MODE:  mode_sh  <= wr_data[MODE_W-1:0];
            A_SCLK:  sclk_sh  <= wr_data[SCLK_W-1:0];
            A_FRAME: frame_sh <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge bclk) begin
    if (brst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_MODE:  rd_data <= DATA_W'(mode_sh);
        A_SCLK:  rd_data <= DATA_W'(sclk_sh);
        A_FRAME: rd_data <= frame_sh;
        A_STAT:  rd_data <= DATA_W'({err, en_s, busy});
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ccs_if_apply.sv
module ccs_if_apply
  import ccs_pkg::*;
#(
  parameter int MODE_W  = 16,
  parameter int SCLK_W  = 24,
  parameter int FRAME_W = 32
) (
  input  logic               iclk,
  input  logic               irst,
  input  logic               req_s,
  input  cmd_t               cmd_q,
  input  logic [MODE_W-1:0]  mode_sh,
  input  logic [SCLK_W-1:0]  sclk_sh,
  input  logic [FRAME_W-1:0] frame_sh,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic [SCLK_W-1:0]  cfg_sclk,
  output logic [FRAME_W-1:0] cfg_frame,
  output logic               if_en,
  output logic               start_pulse,
  output logic               last_pulse,
  output logic               srst_pulse,
  output logic               ack_tgl,
  output logic               arrive
);
  logic req_d;

  // A new request is any change of the synchronized toggle.
  assign arrive = req_s ^ req_d;

  always_ff @(posedge iclk) begin
    if (irst) begin
      req_d       <= 1'b0;
      ack_tgl     <= 1'b0;
      cfg_mode    <= '0;
      cfg_sclk    <= '0;
      cfg_frame   <= '0;
      if_en       <= 1'b0;
      start_pulse <= 1'b0;
      last_pulse  <= 1'b0;
      srst_pulse  <= 1'b0;
    end else begin
      req_d       <= req_s;
      start_pulse <= 1'b0;
      last_pulse  <= 1'b0;
      srst_pulse  <= 1'b0;
      if (arrive) begin
        ack_tgl <= ~ack_tgl;
        if (cmd_q.srst) begin
          cfg_mode   <= '0;
          cfg_sclk   <= '0;
          cfg_frame  <= '0;
          if_en      <= 1'b0;
          srst_pulse <= 1'b1;
        end else begin
          if (cmd_q.commit) begin
            cfg_mode  <= mode_sh;
            cfg_sclk  <= sclk_sh;
            cfg_frame <= frame_sh;
          end
          if (cmd_q.dis)     if_en <= 1'b0;
          else if (cmd_q.en) if_en <= 1'b1;
          start_pulse <= cmd_q.start;
          last_pulse  <= cmd_q.last;
        end
      end
    end
  end
endmodule

// File: rtl/cdc_cfg_commit.sv
module cdc_cfg_commit
  import ccs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int MODE_W      = 16,
  parameter int SCLK_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              iclk,
  input  logic              irst,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [SCLK_W-1:0] cfg_sclk,
  output logic [DATA_W-1:0] cfg_frame,
  output logic              if_enabled,
  output logic              start_pulse,
  output logic              last_pulse,
  output logic              srst_pulse
);
  logic              req_tgl, req_s, ack_tgl, ack_s, en_s, busy, err, arrive;
  cmd_t              cmd_q;
  logic [MODE_W-1:0] mode_sh;
  logic [SCLK_W-1:0] sclk_sh;
  logic [DATA_W-1:0] frame_sh;
  logic [1:0]        back_s;

  ccs_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .SCLK_W(SCLK_W)
  ) u_bus (
    .bclk(bclk), .brst(brst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_s(ack_s), .en_s(en_s), .req_tgl(req_tgl), .cmd_q(cmd_q),
    .mode_sh(mode_sh), .sclk_sh(sclk_sh), .frame_sh(frame_sh),
    .busy(busy), .err(err)
  );

  ccs_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(iclk), .rst(irst), .d(req_tgl), .q(req_s)
  );

  ccs_if_apply #(
    .MODE_W(MODE_W), .SCLK_W(SCLK_W), .FRAME_W(DATA_W)
  ) u_if (
    .iclk(iclk), .irst(irst), .req_s(req_s), .cmd_q(cmd_q),
    .mode_sh(mode_sh), .sclk_sh(sclk_sh), .frame_sh(frame_sh),
    .cfg_mode(cfg_mode), .cfg_sclk(cfg_sclk), .cfg_frame(cfg_frame),
    .if_en(if_enabled), .start_pulse(start_pulse), .last_pulse(last_pulse),
    .srst_pulse(srst_pulse), .ack_tgl(ack_tgl), .arrive(arrive)
  );

  ccs_sync2 #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk(bclk), .rst(brst), .d({if_enabled, ack_tgl}), .q(back_s)
  );
  assign ack_s = back_s[0];
  assign en_s  = back_s[1];
endmodule

// File: rtl/cdc_cfg_commit_chk.sv
module cdc_cfg_commit_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int MODE_W = 16,
  parameter int SCLK_W = 24
) (
  input logic              bclk,
  input logic              brst,
  input logic              iclk,
  input logic              irst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic [MODE_W-1:0] mode_sh,
  input logic [SCLK_W-1:0] sclk_sh,
  input logic [DATA_W-1:0] frame_sh,
  input logic              arrive,
  input logic [MODE_W-1:0] cfg_mode,
  input logic [SCLK_W-1:0] cfg_sclk,
  input logic [DATA_W-1:0] cfg_frame,
  input logic              if_enabled,
  input logic              start_pulse,
  input logic              last_pulse,
  input logic              srst_pulse
);
  a_r4_busy_from_cmd: assert property (@(posedge bclk) disable iff (brst)
    $rose(busy) |-> $past(wr_en && wr_addr == ADDR_W'(ccs_pkg::ADDR_CMD)));

  a_r7_shadow_hold: assert property (@(posedge bclk) disable iff (brst)
    (wr_en && busy) |=> ($stable(mode_sh) && $stable(sclk_sh) && $stable(frame_sh)));

  a_r3_cfg_on_arrival: assert property (@(posedge iclk) disable iff (irst)
    !($stable(cfg_mode) && $stable(cfg_sclk) && $stable(cfg_frame)) |-> $past(arrive));

  a_r6_start_single: assert property (@(posedge iclk) disable iff (irst)
    start_pulse |=> !start_pulse);

  a_r6_last_single: assert property (@(posedge iclk) disable iff (irst)
    last_pulse |=> !last_pulse);

  a_r8_srst_clears: assert property (@(posedge iclk) disable iff (irst)
    srst_pulse |-> (!if_enabled && cfg_mode == '0 && cfg_sclk == '0 && cfg_frame == '0
                    && !start_pulse && !last_pulse));
endmodule

bind cdc_cfg_commit cdc_cfg_commit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .SCLK_W(SCLK_W)
) u_chk (
  .bclk(bclk), .brst(brst), .iclk(iclk), .irst(irst),
  .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
  .mode_sh(mode_sh), .sclk_sh(sclk_sh), .frame_sh(frame_sh),
  .arrive(arrive), .cfg_mode(cfg_mode), .cfg_sclk(cfg_sclk), .cfg_frame(cfg_frame),
  .if_enabled(if_enabled), .start_pulse(start_pulse), .last_pulse(last_pulse),
  .srst_pulse(srst_pulse)
);

// File: tb/cdc_cfg_commit_tb.sv
module cdc_cfg_commit_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int MODE_W = 16;
  localparam int SCLK_W = 24;

  logic              bclk = 1'b0, iclk = 1'b0;
  logic              brst = 1'b1, irst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [MODE_W-1:0] cfg_mode;
  logic [SCLK_W-1:0] cfg_sclk;
  logic [DATA_W-1:0] cfg_frame;
  logic              if_enabled, start_pulse, last_pulse, srst_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];   // scoreboard: 1 start, 2 last, 3 soft reset

  always #2.5 bclk = ~bclk;   // 200 MHz
  always #5.5 iclk = ~iclk;

  cdc_cfg_commit u_dut (
    .bclk(bclk), .brst(brst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .iclk(iclk), .irst(irst), .cfg_mode(cfg_mode), .cfg_sclk(cfg_sclk),
    .cfg_frame(cfg_frame), .if_enabled(if_enabled), .start_pulse(start_pulse),
    .last_pulse(last_pulse), .srst_pulse(srst_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Both tasks are entered at a bclk falling edge and leave at the next one.
  task automatic bwrite(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge bclk);
    wr_en = 1'b0;
  endtask

  task automatic bread(input int a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    @(negedge bclk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    s = 32'h1;
    for (int i = 0; i < 200; i++) begin
      bread(4, s);
      if (!s[0]) break;
    end
    chk(tag, {31'd0, s[0]}, 32'd0);
  endtask

  // Monitor: every strobe must match the next expected scoreboard entry.
  task automatic pop_pulse(input int kind, input string tag);
    int e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual=pulse%0d expected=none", tag, kind);
    end else begin
      e = exp_q.pop_front();
      if (e != kind) begin
        errors++;
        $display("FAIL %s: actual=pulse%0d expected=pulse%0d", tag, kind, e);
      end
    end
  endtask

  always @(negedge iclk) begin
    if (!irst) begin
      if (start_pulse) pop_pulse(1, "R6 start strobe");
      if (last_pulse)  pop_pulse(2, "R6 last strobe");
      if (srst_pulse)  pop_pulse(3, "R8 reset strobe");
    end
  end

  initial begin
    repeat (100000) @(posedge bclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (8) @(negedge iclk);
    irst = 1'b0;
    @(negedge bclk);
    brst = 1'b0;
    @(negedge bclk);

    // R1: reset state
    bread(4, v);  chk("R1 status", v, 32'd0);
    bread(1, v);  chk("R1 mode staging", v, 32'd0);
    chk("R1 cfg_mode", 32'(cfg_mode), 32'd0);
    chk("R1 cfg_frame", cfg_frame, 32'd0);
    chk("R1 if_enabled", {31'd0, if_enabled}, 32'd0);

    // R9: command write with no command bits
    bwrite(0, 32'h0000_0070);
    bread(4, v);  chk("R9 no busy", v, 32'd0);

    // R2: staging writes read back, outputs untouched
    bwrite(1, 32'h0000_A5C3);
    bwrite(2, 32'h0012_3456);
    bwrite(3, 32'hDEAD_BEEF);
    bread(1, v);  chk("R2 mode readback", v, 32'h0000_A5C3);
    bread(2, v);  chk("R2 sclk readback", v, 32'h0012_3456);
    bread(3, v);  chk("R2 frame readback", v, 32'hDEAD_BEEF);
    repeat (10) @(negedge bclk);
    chk("R2 cfg_mode held", 32'(cfg_mode), 32'd0);

    // R3, R4: commit
    bwrite(0, 32'h1 << 8);
    bread(4, v);  chk("R4 busy after commit", {31'd0, v[0]}, 32'd1);
    wait_idle("R4 busy clears");
    chk("R3 cfg_mode", 32'(cfg_mode), 32'h0000_A5C3);
    chk("R3 cfg_sclk", 32'(cfg_sclk), 32'h0012_3456);
    chk("R3 cfg_frame", cfg_frame, 32'hDEAD_BEEF);

    // R5: enable, status only after crossing
    bwrite(0, 32'h1);
    bread(4, v);  chk("R5 enabled hidden while busy", v[2:0], 32'd1);
    wait_idle("R5 enable idle");
    bread(4, v);  chk("R5 enabled status", v, 32'h2);
    chk("R5 if_enabled set", {31'd0, if_enabled}, 32'd1);
    bwrite(0, 32'h3);
    wait_idle("R5 dual idle");
    chk("R5 disable wins", {31'd0, if_enabled}, 32'd0);
    bread(4, v);  chk("R5 status disabled", v, 32'd0);
    bwrite(0, 32'h1);
    wait_idle("R5 re-enable idle");

    // R6: strobes through scoreboard
    exp_q.push_back(1);
    bwrite(0, 32'h1 << 9);
    wait_idle("R6 start idle");
    exp_q.push_back(2);
    bwrite(0, 32'h1 << 24);
    wait_idle("R6 last idle");
    exp_q.push_back(1);
    exp_q.push_back(2);
    bwrite(0, (32'h1 << 9) | (32'h1 << 24));
    wait_idle("R6 both idle");

    // R7: writes while busy are dropped and flagged
    bwrite(1, 32'h0000_1111);
    bwrite(0, 32'h1 << 8);
    bwrite(1, 32'h0000_2222);
    bwrite(0, 32'h1 << 9);          // no scoreboard entry: must not reach the interface
    bread(4, v);  chk("R7 error flag set", {29'd0, v[2:0]}, 32'h7);
    wait_idle("R7 idle");
    bread(1, v);  chk("R7 staging unchanged", v, 32'h0000_1111);
    chk("R7 committed value", 32'(cfg_mode), 32'h0000_1111);
    bread(4, v);  chk("R7 error cleared by read", v, 32'h2);

    // R8: soft reset overrides start
    exp_q.push_back(3);
    bwrite(0, (32'h1 << 7) | (32'h1 << 9));
    bread(1, v);  chk("R8 staging cleared", v, 32'd0);
    wait_idle("R8 idle");
    chk("R8 cfg_mode cleared", 32'(cfg_mode), 32'd0);
    chk("R8 cfg_frame cleared", cfg_frame, 32'd0);
    chk("R8 if_enabled cleared", {31'd0, if_enabled}, 32'd0);
    bread(4, v);  chk("R8 status", v, 32'd0);

    repeat (20) @(negedge iclk);
    chk("R6 scoreboard drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule